// File: doc/BRIEF.md
# Pulse-Distance Frame Validator

This block sits behind the bit-capture stage of an infrared remote-control receiver. The capture stage presents a 32-bit raw word together with a one-cycle strobe when a frame is complete. The word holds four bytes: an address, the address inverted, a command, and the command inverted. Each byte is sent least-significant bit first, but the capture stage shifts bits in from the right. Every byte therefore arrives bit-reversed. The first bit on the air ends up in bit 31.

On each strobe, the validator reverses the bits inside every byte and checks both complement pairs. When both pairs hold, it latches the address and command into holding registers that feed a display, and it raises a one-cycle valid pulse. When either pair fails, it keeps the last good values, raises a one-cycle error pulse, and bumps a saturating count of rejected frames.

The controller has three states:
- `ST_IDLE`: no strobe was seen last cycle.
- `ST_ACCEPT`: the previous strobe carried a good frame.
- `ST_REJECT`: the previous strobe carried a bad frame.

From any state, a strobe with both checks passing moves to `ST_ACCEPT`. A strobe with a failing check moves to `ST_REJECT`. No strobe moves to `ST_IDLE`.

Top module: `ir_frame_validator`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `cmd_q`, `addr_q`, `reject_cnt`, `valid_p` and `error_p` are all zero.
- R2: The address is `raw_word[31:24]` bit-reversed, so bit 31 becomes address bit 0. The command is `raw_word[15:8]` bit-reversed, so bit 15 becomes command bit 0.
- R3: A frame is good only when `raw_word[23:16]` equals the bitwise inverse of `raw_word[31:24]` and `raw_word[7:0]` equals the bitwise inverse of `raw_word[15:8]`.
- R4: For a good frame, `cmd_q` and `addr_q` take the new values at the clock edge that samples `frame_done` high. `valid_p` is high for exactly the following cycle.
- R5: For a bad frame, `error_p` is high for exactly the following cycle, and `cmd_q` and `addr_q` keep their previous values.
- R6: While `frame_done` is low, changes on `raw_word` leave every output unchanged.
- R7: `reject_cnt` rises by one for each bad frame and stays at 255 once it reaches 255.
- R8: Strobes on consecutive cycles are each classified and applied in order.
- R9: The raw word 0x00FFA25D yields command 0x45 and address 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_done | input | 1 | One-cycle strobe: `raw_word` holds a complete frame |
| raw_word | input | 32 | Captured frame bits, first bit received in bit 31 |
| cmd_q | output | 8 | Last accepted command |
| addr_q | output | 8 | Last accepted address |
| valid_p | output | 1 | One-cycle pulse after a good frame |
| error_p | output | 1 | One-cycle pulse after a bad frame |
| reject_cnt | output | 8 | Saturating count of bad frames |

## Verification
The hardest state to reach from the ports is a saturated reject counter that is then followed by more bad frames. The bench reaches it by driving a long run of directed corrupted frames, one per strobe, past 255. It then confirms the count stays put while good frames still load the holding registers.

Back-to-back strobes are a second case that is easy to miss. The bench pairs a bad frame with a good one on consecutive cycles. Random words mostly fail the checks, so the random phase builds half of its frames with true complements to keep both paths busy.

// File: rtl/irfv_pkg.sv
package irfv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCEPT = 2'd1,
        ST_REJECT = 2'd2
    } fv_state_t;
endpackage

// File: rtl/ir_byte_unpack.sv
// Reverses bit order inside each byte of a word.
module ir_byte_unpack #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 4
) (
    input  logic [NBYTES*BYTE_W-1:0] word_in,
    output logic [NBYTES*BYTE_W-1:0] word_out
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
            assign word_out[b*BYTE_W + i] = word_in[b*BYTE_W + BYTE_W - 1 - i];
        end
    end
endmodule

// File: rtl/ir_frame_check.sv
// Both complement pairs must hold for a frame to be good.
module ir_frame_check #(
    parameter int BYTE_W = 8
) (
    input  logic [4*BYTE_W-1:0] word_in,
    output logic                pass
);
    logic [BYTE_W-1:0] a_byte, a_inv, c_byte, c_inv;

    assign a_byte = word_in[4*BYTE_W-1 -: BYTE_W];
    assign a_inv  = word_in[3*BYTE_W-1 -: BYTE_W];
    assign c_byte = word_in[2*BYTE_W-1 -: BYTE_W];
    assign c_inv  = word_in[BYTE_W-1 -: BYTE_W];
    assign pass   = (a_inv == ~a_byte) && (c_inv == ~c_byte);
endmodule

// File: rtl/ir_reject_counter.sv
// Saturating event counter.
module ir_reject_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (bump && count != TOP)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/ir_frame_validator.sv
module ir_frame_validator
    import irfv_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_done,
    input  logic [4*BYTE_W-1:0] raw_word,
    output logic [BYTE_W-1:0]   cmd_q,
    output logic [BYTE_W-1:0]   addr_q,
    output logic                valid_p,
    output logic                error_p,
    output logic [CNT_W-1:0]    reject_cnt
);
    localparam int WORD_W = 4 * BYTE_W;

    fv_state_t         state_q, state_d;
    logic [WORD_W-1:0] flipped;
    logic              frame_ok;
    logic              take_frame;
    logic              drop_frame;

    ir_byte_unpack #(.BYTE_W(BYTE_W), .NBYTES(4)) u_unpack (
        .word_in  (raw_word),
        .word_out (flipped)
    );

    ir_frame_check #(.BYTE_W(BYTE_W)) u_check (
        .word_in (raw_word),
        .pass    (frame_ok)
    );

    assign take_frame = frame_done && frame_ok;
    assign drop_frame = frame_done && !frame_ok;

    ir_reject_counter #(.CNT_W(CNT_W)) u_rejects (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (drop_frame),
        .count (reject_cnt)
    );

    // Next-state selection: every state reacts to a new strobe.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ACCEPT, ST_REJECT: begin
                if (take_frame)
                    state_d = ST_ACCEPT;
                else if (drop_frame)
                    state_d = ST_REJECT;
                else
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Holding registers: load only on a good frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            addr_q <= '0;
        end else if (take_frame) begin
            addr_q <= flipped[WORD_W-1 -: BYTE_W];
            cmd_q  <= flipped[2*BYTE_W-1 -: BYTE_W];
        end
    end

    // Status pulses decoded from the state.
    always_comb begin
        valid_p = 1'b0;
        error_p = 1'b0;
        unique case (state_q)
            ST_ACCEPT: valid_p = 1'b1;
            ST_REJECT: error_p = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/ir_frame_validator_chk.sv
module ir_frame_validator_chk #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frame_done,
    input logic [4*BYTE_W-1:0] raw_word,
    input logic [BYTE_W-1:0]   cmd_q,
    input logic [BYTE_W-1:0]   addr_q,
    input logic                valid_p,
    input logic                error_p,
    input logic [CNT_W-1:0]    reject_cnt
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic warm;
    always_ff @(posedge clk) begin
        if (!rst_n) warm <= 1'b0;
        else        warm <= 1'b1;
    end

    function automatic logic [BYTE_W-1:0] mirror(input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] r;
        for (int k = 0; k < BYTE_W; k++) r[BYTE_W-1-k] = v[k];
        return r;
    endfunction

    p_pulse_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_p && error_p));

    p_valid_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        warm && valid_p |-> $past(frame_done));

    p_cmd_rev_r2: assert property (@(posedge clk) disable iff (!rst_n)
        warm && valid_p |-> cmd_q == mirror($past(raw_word[2*BYTE_W-1 -: BYTE_W])));

    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        warm && !$past(frame_done) |-> $stable(cmd_q) && $stable(addr_q) && $stable(reject_cnt));

    p_hold_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        warm && error_p |-> $stable(cmd_q) && $stable(addr_q));

    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        warm && $past(reject_cnt) == TOP |-> reject_cnt == TOP);

    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        warm && error_p && $past(reject_cnt) != TOP |-> reject_cnt == $past(reject_cnt) + 1'b1);
endmodule

bind ir_frame_validator ir_frame_validator_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .raw_word   (raw_word),
    .cmd_q      (cmd_q),
    .addr_q     (addr_q),
    .valid_p    (valid_p),
    .error_p    (error_p),
    .reject_cnt (reject_cnt)
);

// File: tb/sim_ir_frame_validator.sv
`timescale 1ns/1ps
module sim_ir_frame_validator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_done = 1'b0;
    logic [31:0] raw_word = '0;
    logic [7:0]  cmd_q, addr_q, reject_cnt;
    logic        valid_p, error_p;

    int checks = 0;
    int failures = 0;
    logic [7:0] e_cmd = 0, e_addr = 0, e_cnt = 0;

    always #2.5 clk = ~clk;

    ir_frame_validator u0 (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .raw_word(raw_word),
        .cmd_q(cmd_q), .addr_q(addr_q), .valid_p(valid_p), .error_p(error_p),
        .reject_cnt(reject_cnt)
    );

    function automatic logic [7:0] flip8(input logic [7:0] v);
        logic [7:0] r = '0;
        for (int k = 0; k < 8; k++) r = {r[6:0], v[k]};
        return r;
    endfunction

    function automatic logic good(input logic [31:0] w);
        return (w[23:16] == ~w[31:24]) && (w[7:0] == ~w[15:8]);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model(input logic [31:0] w);
        if (good(w)) begin
            e_addr = flip8(w[31:24]);
            e_cmd  = flip8(w[15:8]);
        end else if (e_cnt != 8'hFF) begin
            e_cnt = e_cnt + 1;
        end
    endtask

    task automatic check_out(input string req, input logic was_good);
        chk({req, " valid"}, valid_p, was_good);
        chk({req, " error"}, error_p, !was_good);
        chk({req, " cmd"}, cmd_q, e_cmd);
        chk({req, " addr"}, addr_q, e_addr);
        chk({req, " cnt"}, reject_cnt, e_cnt);
    endtask

    // One strobe, then look at the outputs in the following cycle.
    task automatic send(input string req, input logic [31:0] w);
        @(negedge clk);
        raw_word = w;
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        model(w);
        check_out(req, good(w));
    endtask

    function automatic logic [31:0] build(input logic [7:0] a, input logic [7:0] c);
        return {a, ~a, c, ~c};
    endfunction

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed = 32'd2024;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cmd", cmd_q, 0);
        chk("R1 addr", addr_q, 0);
        chk("R1 cnt", reject_cnt, 0);
        chk("R1 valid", valid_p, 0);
        chk("R1 error", error_p, 0);

        // R9 worked example
        send("R9", 32'h00FFA25D);
        chk("R9 cmd value", cmd_q, 8'h45);
        // R2 ordering: address bit 0 taken from raw bit 31
        send("R2", build(8'h80, 8'h01));
        chk("R2 addr bit", addr_q, 8'h01);
        chk("R2 cmd bit", cmd_q, 8'h80);
        // pulse lasts one cycle (R4)
        @(negedge clk);
        chk("R4 one-cycle valid", valid_p, 0);
        // R3 / R5: address pair broken, command pair broken
        send("R3 addr bad", {8'h12, 8'hED ^ 8'h01, 8'h34, ~8'h34});
        send("R3 cmd bad", {8'h12, ~8'h12, 8'h34, 8'h34});
        send("R5 both bad", 32'h0);
        @(negedge clk);
        chk("R5 one-cycle error", error_p, 0);
        // R6: raw changes with no strobe
        raw_word = build(8'h5A, 8'h3C);
        @(negedge clk);
        raw_word = 32'hFFFF_FFFF;
        @(negedge clk);
        chk("R6 cmd", cmd_q, e_cmd);
        chk("R6 addr", addr_q, e_addr);
        chk("R6 cnt", reject_cnt, e_cnt);
        chk("R6 valid", valid_p, 0);
        // R8: bad then good on consecutive cycles
        @(negedge clk);
        raw_word = 32'h1;
        frame_done = 1'b1;
        @(negedge clk);
        model(32'h1);
        check_out("R8 first", 1'b0);
        raw_word = build(8'hC3, 8'h96);
        @(negedge clk);
        frame_done = 1'b0;
        model(build(8'hC3, 8'h96));
        check_out("R8 second", 1'b1);

        // random mix, R2 R3 R4 R5
        for (int n = 0; n < 200; n++) begin
            logic [31:0] w;
            if ($urandom % 2) w = build(8'($urandom), 8'($urandom));
            else              w = $urandom;
            send("R3 random", w);
        end

        // R7 saturation
        for (int n = 0; n < 270; n++) send("R7 sat", {8'h00, 8'h00, 8'h11, 8'h22});
        chk("R7 top", reject_cnt, 8'hFF);
        send("R7 good after sat", build(8'h0F, 8'hF0));

        // R1 reset again clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 re-reset cnt", reject_cnt, 0);
        chk("R1 re-reset cmd", cmd_q, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule